// File: doc/BRIEF.md
# Masked Crosspoint Field Switch

This block moves one W-bit field of a four-field input word to one chosen field of a four-field output word. It does not hold a separate path for each of the sixteen source and destination pairs. Instead it keeps a single shared bank of W product terms. A source mask blanks every input field except the chosen one, so each term sees exactly one live bit. A destination mask then gates the shared term vector onto the chosen output field or fields.

The four-bit control word is split into two 2-bit selectors. One selector picks the source field and the other picks the destination field. An extra mode input replaces the destination selector with a four-bit enable vector, so one source can be copied to several destinations in the same cycle. Output fields that are not enabled read as zero. The result is registered, so a change on the control or data inputs appears on the output one clock later.

Top module: `xfield_switch`

## Requirements
- R1: While `rst` is high at a rising clock edge, every bit of `out_bus` becomes 0 at that edge.
- R2: `src_sel` value s (0 to 3) takes its source from input field s, which is `in_bus[s*W +: W]`.
- R3: With `fanout_en` low, `dst_sel` value d (0 to 3) drives output field d, which is `out_bus[d*W +: W]`.
- R4: Bit i of the source field appears at bit i of every driven destination field. No bit is reversed or shifted.
- R5: Output fields that are not enabled read as all zeros.
- R6: The three input fields that are not selected have no effect on `out_bus`.
- R7: With `fanout_en` high, bit k of `dst_vec` enables output field k, and every enabled field carries the same source. A zero vector gives an all-zero output.
- R8: `out_bus` changes only at a rising clock edge. It reflects the inputs sampled at that edge, which is one cycle of latency.
- R9: With `fanout_en` low, `dst_vec` has no effect on `out_bus`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| src_sel | input | 2 | Source field selector (first control pair) |
| dst_sel | input | 2 | Destination field selector (second control pair) |
| fanout_en | input | 1 | 1: use `dst_vec` as the destination enables |
| dst_vec | input | 4 | Per-field destination enables in fan-out mode |
| in_bus | input | 4*W | Four packed input fields; field k is at bits k*W and up |
| out_bus | output | 4*W | Four packed registered output fields |

## Verification
The bench walks all sixteen source and destination pairs with asymmetric bit patterns. A design that swaps the two selectors, reverses the field order or reverses the bits within a field would produce the wrong field or a mirrored value. The bench also changes the unselected input fields while holding the route fixed. A source mask that lets a second field through would then OR foreign bits into the result. Fan-out is checked with several enable vectors, including all zeros and all ones. A stray `dst_vec` is applied while fan-out mode is off, which catches a destination mask that decodes the wrong control input. The bench samples just before a clock edge as well as just after it, so a combinational bypass or an extra pipeline stage would show up.

// File: rtl/xpt_pkg.sv
package xpt_pkg;
    localparam int XPT_FIELDS = 4;
    localparam int XPT_SEL_W  = $clog2(XPT_FIELDS);

    typedef logic [XPT_FIELDS-1:0] field_vec_t;
    typedef logic [XPT_SEL_W-1:0]  field_sel_t;

    typedef struct packed {
        field_sel_t src;
        field_sel_t dst;
    } route_ctl_t;

    function automatic field_vec_t sel_to_onehot(input field_sel_t sel);
        field_vec_t v;
        v = '0;
        v[sel] = 1'b1;
        return v;
    endfunction
endpackage

// File: rtl/xpt_src_mask.sv
module xpt_src_mask
    import xpt_pkg::*;
#(
    parameter int FIELD_W = 8
) (
    input  logic [XPT_FIELDS*FIELD_W-1:0] in_bus,
    input  field_sel_t                    src,
    output logic [FIELD_W-1:0]            term
);
    field_vec_t live;

    assign live = sel_to_onehot(src);

    // One shared product term per bit position; masked fields are don't-care.
    for (genvar b = 0; b < FIELD_W; b++) begin : g_term
        always_comb begin
            term[b] = 1'b0;
            for (int f = 0; f < XPT_FIELDS; f++) begin
                term[b] = term[b] | (live[f] & in_bus[f*FIELD_W + b]);
            end
        end
    end
endmodule

// File: rtl/xpt_dst_mask.sv
module xpt_dst_mask
    import xpt_pkg::*;
(
    input  field_sel_t dst,
    input  logic       fanout_en,
    input  field_vec_t dst_vec,
    output field_vec_t drive
);
    assign drive = fanout_en ? dst_vec : sel_to_onehot(dst);
endmodule

// File: rtl/xpt_out_reg.sv
module xpt_out_reg
    import xpt_pkg::*;
#(
    parameter int FIELD_W = 8
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [FIELD_W-1:0]            term,
    input  field_vec_t                    drive,
    output logic [XPT_FIELDS*FIELD_W-1:0] out_q
);
    for (genvar f = 0; f < XPT_FIELDS; f++) begin : g_fld
        always_ff @(posedge clk) begin
            if (rst) begin
                out_q[f*FIELD_W +: FIELD_W] <= '0;
            end else begin
                out_q[f*FIELD_W +: FIELD_W] <= drive[f] ? term : '0;
            end
        end

        AST_IDLE_FIELD_ZERO: assert property (@(posedge clk) disable iff (rst)
            !drive[f] |=> (out_q[f*FIELD_W +: FIELD_W] == '0)); // R5
    end

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (out_q == '0)); // R1
endmodule

// File: rtl/xfield_switch.sv
module xfield_switch
    import xpt_pkg::*;
#(
    parameter int FIELD_W = 8
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [1:0]                    src_sel,
    input  logic [1:0]                    dst_sel,
    input  logic                          fanout_en,
    input  logic [3:0]                    dst_vec,
    input  logic [XPT_FIELDS*FIELD_W-1:0] in_bus,
    output logic [XPT_FIELDS*FIELD_W-1:0] out_bus
);
    route_ctl_t         ctl;
    logic [FIELD_W-1:0] term;
    field_vec_t         drive;
    field_vec_t         fld_nz;

    assign ctl.src = src_sel;
    assign ctl.dst = dst_sel;

    xpt_src_mask #(.FIELD_W(FIELD_W)) u_src (
        .in_bus (in_bus),
        .src    (ctl.src),
        .term   (term)
    );

    xpt_dst_mask u_dst (
        .dst       (ctl.dst),
        .fanout_en (fanout_en),
        .dst_vec   (dst_vec),
        .drive     (drive)
    );

    xpt_out_reg #(.FIELD_W(FIELD_W)) u_reg (
        .clk   (clk),
        .rst   (rst),
        .term  (term),
        .drive (drive),
        .out_q (out_bus)
    );

    always_comb begin
        for (int f = 0; f < XPT_FIELDS; f++) begin
            fld_nz[f] = |out_bus[f*FIELD_W +: FIELD_W];
        end
    end

    AST_ROUTE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        !fanout_en |=> (out_bus[$past(dst_sel)*FIELD_W +: FIELD_W]
                        == $past(in_bus[src_sel*FIELD_W +: FIELD_W]))); // R2

    AST_ONE_DEST_ONLY: assert property (@(posedge clk) disable iff (rst)
        !fanout_en |=> ($countones(fld_nz) <= 1)); // R9

    AST_FANOUT_NONE: assert property (@(posedge clk) disable iff (rst)
        (fanout_en && dst_vec == '0) |=> (out_bus == '0)); // R7
endmodule

// File: tb/test_xfield_switch.sv
module test_xfield_switch;
    localparam int W = 8;
    localparam int NF = 4;

    logic              clk = 1'b0;
    logic              rst;
    logic [1:0]        src_sel;
    logic [1:0]        dst_sel;
    logic              fanout_en;
    logic [3:0]        dst_vec;
    logic [NF*W-1:0]   in_bus;
    logic [NF*W-1:0]   out_bus;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    xfield_switch #(.FIELD_W(W)) i_xfield_switch (
        .clk       (clk),
        .rst       (rst),
        .src_sel   (src_sel),
        .dst_sel   (dst_sel),
        .fanout_en (fanout_en),
        .dst_vec   (dst_vec),
        .in_bus    (in_bus),
        .out_bus   (out_bus)
    );

    function automatic logic [NF*W-1:0] model(input logic [1:0] s, input logic [1:0] d,
                                              input logic fo, input logic [3:0] v,
                                              input logic [NF*W-1:0] din);
        logic [NF*W-1:0] r;
        logic [3:0] en;
        r  = '0;
        en = fo ? v : (4'b0001 << d);
        for (int k = 0; k < NF; k++) begin
            if (en[k]) r[k*W +: W] = din[s*W +: W];
        end
        return r;
    endfunction

    task automatic check(input string req, input logic [NF*W-1:0] exp);
        checks++;
        if (out_bus !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, out_bus, exp);
        end
    endtask

    task automatic drive_in(input logic [1:0] s, input logic [1:0] d, input logic fo,
                            input logic [3:0] v, input logic [NF*W-1:0] din);
        @(negedge clk);
        src_sel = s; dst_sel = d; fanout_en = fo; dst_vec = v; in_bus = din;
        @(posedge clk);
        #1;
    endtask

    task automatic t_reset();
        @(negedge clk);
        rst = 1'b1; in_bus = '1; src_sel = 2'd1; dst_sel = 2'd2; fanout_en = 1'b1; dst_vec = 4'hF;
        @(posedge clk); #1;
        check("R1", '0);
        @(posedge clk); #1;
        check("R1", '0);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_all_routes();
        logic [NF*W-1:0] din;
        din = 32'hC3_5A_81_17;
        for (int s = 0; s < NF; s++) begin
            for (int d = 0; d < NF; d++) begin
                drive_in(s[1:0], d[1:0], 1'b0, 4'h0, din);
                check("R2_R3_R5", model(s[1:0], d[1:0], 1'b0, 4'h0, din));
            end
        end
    endtask

    task automatic t_bit_order();
        drive_in(2'd0, 2'd3, 1'b0, 4'h0, 32'h00_00_00_01);
        check("R4", 32'h01_00_00_00);
        drive_in(2'd3, 2'd0, 1'b0, 4'h0, 32'h80_00_00_00);
        check("R4", 32'h00_00_00_80);
        drive_in(2'd2, 2'd1, 1'b0, 4'h0, 32'h00_0E_00_00);
        check("R4", 32'h00_00_0E_00);
    endtask

    task automatic t_isolation();
        drive_in(2'd1, 2'd2, 1'b0, 4'h0, 32'h00_00_3C_00);
        check("R6", 32'h00_3C_00_00);
        drive_in(2'd1, 2'd2, 1'b0, 4'h0, 32'hFF_FF_3C_FF);
        check("R6", 32'h00_3C_00_00);
        drive_in(2'd1, 2'd2, 1'b0, 4'h0, 32'hA5_5A_3C_96);
        check("R6", 32'h00_3C_00_00);
    endtask

    task automatic t_fanout();
        logic [NF*W-1:0] din;
        din = 32'h11_22_6B_44;
        drive_in(2'd1, 2'd0, 1'b1, 4'hF, din);
        check("R7", 32'h6B_6B_6B_6B);
        drive_in(2'd1, 2'd0, 1'b1, 4'b1010, din);
        check("R7", 32'h6B_00_6B_00);
        drive_in(2'd3, 2'd0, 1'b1, 4'b0110, din);
        check("R7", 32'h00_11_11_00);
        drive_in(2'd1, 2'd2, 1'b1, 4'h0, din);
        check("R7", 32'h0);
    endtask

    task automatic t_vec_ignored();
        drive_in(2'd2, 2'd0, 1'b0, 4'hF, 32'h00_77_00_00);
        check("R9", 32'h00_00_00_77);
        drive_in(2'd2, 2'd3, 1'b0, 4'b0110, 32'h00_77_00_00);
        check("R9", 32'h77_00_00_00);
    endtask

    task automatic t_latency();
        drive_in(2'd0, 2'd1, 1'b0, 4'h0, 32'h00_00_00_5E);
        check("R8", 32'h00_00_5E_00);
        @(negedge clk);
        src_sel = 2'd0; dst_sel = 2'd2; in_bus = 32'h00_00_00_E5;
        #1;
        check("R8", 32'h00_00_5E_00);
        @(posedge clk); #1;
        check("R8", 32'h00_E5_00_00);
    endtask

    initial begin
        #(20 * 100000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; src_sel = '0; dst_sel = '0; fanout_en = 1'b0; dst_vec = '0; in_bus = '0;
        t_reset();
        t_all_routes();
        t_bit_order();
        t_isolation();
        t_fanout();
        t_vec_ignored();
        t_latency();
        t_reset();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule